// File: doc/BRIEF.md
# Barrel Shifter with Condition Flags

This block is a combinational 32-bit barrel shifter for an integer datapath. It performs a logical left shift, a logical right shift or an arithmetic right shift of one data word. The shift count comes either from a full register operand, of which only the low five bits count, or from a five-bit immediate field. A single select input chooses between the two.

Alongside the shifted word the block produces a five-bit condition-flag vector. Four flags are recomputed on every shift: zero, sign, overflow and carry. The fifth, the sticky saturation flag, is copied from the incoming flag vector. The flag layout matches the one used by the neighbouring arithmetic units, so the flag register can take the output directly.

The carry flag holds the last bit that left the word. A shift by zero moves no bit out, so in that case the carry is zero and the word passes through unchanged.

Top module: `shf_flag_unit`

## Requirements
- R1: With mode_i = 2'b00 or 2'b10 (bit 0 clear means left), the result is data_i shifted left by the count, with zeros entering at bit 0.
- R2: With mode_i = 2'b01 (bit 0 set means right, bit 1 clear means logical), the result is data_i shifted right by the count, with zeros entering at bit 31.
- R3: With mode_i = 2'b11 (right, arithmetic), the result is data_i shifted right by the count, with the original bit 31 copied into every vacated upper bit.
- R4: For a count n > 0, the carry flag (flags_o bit 3) equals the last bit shifted out. That is data_i[32-n] for a left shift and data_i[n-1] for a right shift.
- R5: For a count of 0, result_o equals data_i and the carry flag is 0, in every mode.
- R6: The overflow flag (flags_o bit 2) is 0 after every shift, whatever flags_i holds.
- R7: The zero flag (flags_o bit 0) is 1 exactly when result_o is all zeros. The sign flag (flags_o bit 1) equals result_o bit 31.
- R8: The saturation flag (flags_o bit 4) equals flags_i bit 4, and no other bit of flags_i affects any output.
- R9: When amt_sel_i = 1 the count is imm_amt_i. When amt_sel_i = 0 the count is reg_amt_i[4:0], and bits 31:5 of reg_amt_i have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 32 | Word to be shifted |
| reg_amt_i | input | 32 | Register-supplied shift count (low 5 bits used) |
| imm_amt_i | input | 5 | Immediate shift count |
| amt_sel_i | input | 1 | 1 selects imm_amt_i, 0 selects reg_amt_i |
| mode_i | input | 2 | Bit 0: 0 left / 1 right; bit 1: arithmetic (right only) |
| flags_i | input | 5 | Incoming flags {SAT, CY, OV, S, Z} |
| result_o | output | 32 | Shifted word |
| flags_o | output | 5 | Outgoing flags {SAT, CY, OV, S, Z} |

## Verification
Carry capture and zero detection can both be set by the same shift. A bench case provokes this by shifting a single set bit exactly off the edge: 0x00000008 right by 4, or 0x80000000 left by 1. For each, the bench expects a zero result together with both Z and CY set. A second meeting point is the zero count. A word full of ones is shifted by zero with every incoming flag set, and the bench expects the word back unchanged, with CY and OV clear, S set and SAT kept. All expected values come from a bit-at-a-time shift model in the bench.

// File: rtl/shf_pkg.sv
package shf_pkg;
  localparam int FLAG_W = 5;
  // flag bit positions, shared with neighbouring arithmetic units
  localparam int FLG_Z   = 0;
  localparam int FLG_S   = 1;
  localparam int FLG_OV  = 2;
  localparam int FLG_CY  = 3;
  localparam int FLG_SAT = 4;
  // mode_i bit meanings
  localparam int MODE_RIGHT = 0;
  localparam int MODE_ARITH = 1;
endpackage

// File: rtl/shf_amt_sel.sv
module shf_amt_sel #(
  parameter int WIDTH = 32,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] reg_amt_i,
  input  logic [AMT_W-1:0] imm_amt_i,
  input  logic             use_imm_i,
  output logic [AMT_W-1:0] amt_o
);
  // upper register bits are deliberately discarded
  logic unused_hi;
  assign unused_hi = ^reg_amt_i[WIDTH-1:AMT_W];

  assign amt_o = use_imm_i ? imm_amt_i : reg_amt_i[AMT_W-1:0];
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
  parameter int WIDTH = 32,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             left_i,
  input  logic             arith_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o
);
  // one guard bit below the word catches the last bit shifted out
  localparam int EW = WIDTH + 1;

  logic [WIDTH-1:0] data_rev;
  logic [WIDTH-1:0] src;
  logic [WIDTH-1:0] out_w;
  logic [WIDTH-1:0] out_rev;
  logic             fill;
  logic [EW-1:0]    stg [AMT_W+1];

  // left shifts are done as right shifts of the bit-reversed word
  for (genvar i = 0; i < WIDTH; i++) begin : g_rev_in
    assign data_rev[i] = data_i[WIDTH-1-i];
  end

  assign src    = left_i ? data_rev : data_i;
  assign fill   = arith_i & ~left_i & data_i[WIDTH-1];
  assign stg[0] = {src, 1'b0};

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stg[k+1] = amt_i[k] ? {{SH{fill}}, stg[k][EW-1:SH]} : stg[k];
  end

  assign out_w  = stg[AMT_W][EW-1:1];
  assign cout_o = stg[AMT_W][0];

  for (genvar i = 0; i < WIDTH; i++) begin : g_rev_out
    assign out_rev[i] = out_w[WIDTH-1-i];
  end

  assign res_o = left_i ? out_rev : out_w;
endmodule

// File: rtl/shf_flags.sv
module shf_flags
  import shf_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]  res_i,
  input  logic              cout_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [FLAG_W-1:0] flags_o
);
  // only SAT survives from the incoming vector
  logic unused_flags;
  assign unused_flags = ^flags_i[FLG_CY:FLG_Z];

  always_comb begin
    flags_o          = '0;
    flags_o[FLG_Z]   = ~|res_i;
    flags_o[FLG_S]   = res_i[WIDTH-1];
    flags_o[FLG_OV]  = 1'b0;
    flags_o[FLG_CY]  = cout_i;
    flags_o[FLG_SAT] = flags_i[FLG_SAT];
  end
endmodule

// File: rtl/shf_flag_unit.sv
module shf_flag_unit
  import shf_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0]  data_i,
  input  logic [WIDTH-1:0]  reg_amt_i,
  input  logic [AMT_W-1:0]  imm_amt_i,
  input  logic              amt_sel_i,
  input  logic [1:0]        mode_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [WIDTH-1:0]  result_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic [AMT_W-1:0] amt;
  logic             left;
  logic             arith;
  logic             cout;

  assign left  = ~mode_i[MODE_RIGHT];
  assign arith = mode_i[MODE_ARITH] & mode_i[MODE_RIGHT];

  shf_amt_sel #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_amt (
    .reg_amt_i (reg_amt_i),
    .imm_amt_i (imm_amt_i),
    .use_imm_i (amt_sel_i),
    .amt_o     (amt)
  );

  shf_barrel #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_barrel (
    .data_i  (data_i),
    .amt_i   (amt),
    .left_i  (left),
    .arith_i (arith),
    .res_o   (result_o),
    .cout_o  (cout)
  );

  shf_flags #(.WIDTH(WIDTH)) u_flags (
    .res_i   (result_o),
    .cout_i  (cout),
    .flags_i (flags_i),
    .flags_o (flags_o)
  );

  always_comb begin
    p_left_zero_fill_r1: assert (!(left && amt != '0) || result_o[0] == 1'b0)
      else $error("left shift did not fill bit 0 with zero");
    p_right_zero_fill_r2: assert (!(!left && !arith && amt != '0) || result_o[WIDTH-1] == 1'b0)
      else $error("logical right shift did not clear msb");
    p_sign_fill_r3: assert (!arith || result_o[WIDTH-1] == data_i[WIDTH-1])
      else $error("arithmetic right shift lost sign");
    p_zero_count_r5: assert (amt != '0 || (result_o == data_i && !flags_o[FLG_CY]))
      else $error("zero count altered word or set carry");
    p_sat_pass_r8: assert (flags_o[FLG_SAT] == flags_i[FLG_SAT])
      else $error("saturation flag not preserved");
  end
endmodule

// File: tb/sim_shf_flag_unit.sv
module sim_shf_flag_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] data_i = '0;
  logic [31:0] reg_amt_i = '0;
  logic [4:0]  imm_amt_i = '0;
  logic        amt_sel_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [4:0]  flags_i = '0;
  logic [31:0] result_o;
  logic [4:0]  flags_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  shf_flag_unit u0 (
    .data_i    (data_i),
    .reg_amt_i (reg_amt_i),
    .imm_amt_i (imm_amt_i),
    .amt_sel_i (amt_sel_i),
    .mode_i    (mode_i),
    .flags_i   (flags_i),
    .result_o  (result_o),
    .flags_o   (flags_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // bit-at-a-time reference: {sat, cy, ov, s, z}
  task automatic model(input logic [31:0] d, input int n, input logic [1:0] m,
                       input logic sat, output logic [31:0] r, output logic [4:0] f);
    logic cy = 1'b0;
    r = d;
    for (int i = 0; i < n; i++) begin
      if (!m[0]) begin
        cy = r[31];
        r  = {r[30:0], 1'b0};
      end else begin
        cy = r[0];
        r  = {(m[1] ? r[31] : 1'b0), r[31:1]};
      end
    end
    f = {sat, cy, 1'b0, r[31], (r == 32'h0)};
  endtask

  task automatic run(input string tag, input logic [31:0] d, input logic [31:0] ra,
                     input logic [4:0] ia, input logic sel, input logic [1:0] m,
                     input logic [4:0] fi);
    logic [31:0] er;
    logic [4:0]  ef;
    int n;
    @(negedge clk);
    data_i = d; reg_amt_i = ra; imm_amt_i = ia; amt_sel_i = sel; mode_i = m; flags_i = fi;
    n = sel ? int'(ia) : int'(ra[4:0]);
    model(d, n, m, fi[4], er, ef);
    #1;
    chk({tag, " result"}, result_o, er);
    chk({tag, " flags"}, {27'h0, flags_o}, {27'h0, ef});
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    #1;
    chk("reset R7 idle result", result_o, 32'h0);
    chk("reset R7 idle flags", {27'h0, flags_o}, 32'h1);
  endtask

  task automatic t_left;
    run("R1 left 4000000F<<1", 32'h4000000F, 32'd1, 5'd0, 1'b0, 2'b00, 5'h00);
    chk("R1 literal", result_o, 32'h8000001E);
    chk("R7 sign after left", {31'h0, flags_o[1]}, 32'h1);
    run("R1 left mode 10", 32'hDEADBEEF, 32'd0, 5'd7, 1'b1, 2'b10, 5'h00);
    run("R4 left carry 80000000<<1", 32'h80000000, 32'd0, 5'd1, 1'b1, 2'b00, 5'h00);
    chk("R4 R7 carry and zero", {27'h0, flags_o}, 32'h09);
  endtask

  task automatic t_right;
    run("R2 right 80000000>>1", 32'h80000000, 32'd1, 5'd0, 1'b0, 2'b01, 5'h00);
    chk("R2 literal", result_o, 32'h40000000);
    run("R2 right 40000000>>1", 32'h40000000, 32'd1, 5'd0, 1'b0, 2'b01, 5'h00);
    run("R4 right 8>>4", 32'h00000008, 32'd4, 5'd0, 1'b0, 2'b01, 5'h00);
    chk("R4 R7 8>>4 flags", {27'h0, flags_o}, 32'h09);
    run("R4 right 1>>4 no carry", 32'h00000001, 32'd0, 5'd4, 1'b1, 2'b01, 5'h00);
  endtask

  task automatic t_arith;
    run("R3 sar 80000000>>1", 32'h80000000, 32'd1, 5'd0, 1'b0, 2'b11, 5'h00);
    chk("R3 literal", result_o, 32'hC0000000);
    run("R3 sar 40000000>>1", 32'h40000000, 32'd1, 5'd0, 1'b0, 2'b11, 5'h00);
    run("R3 sar by 31", 32'h80000001, 32'd31, 5'd0, 1'b0, 2'b11, 5'h00);
  endtask

  task automatic t_zero_count;
    for (int m = 0; m < 4; m++) begin
      run("R5 zero count", 32'hFFFFFFFF, 32'd0, 5'd0, 1'b0, 2'(m), 5'h1F);
      chk("R5 R6 zero count flags", {27'h0, flags_o}, 32'h12);
    end
  endtask

  task automatic t_ov_sat;
    run("R6 ov cleared", 32'h12345678, 32'd3, 5'd0, 1'b0, 2'b00, 5'h0F);
    chk("R6 ov bit", {31'h0, flags_o[2]}, 32'h0);
    chk("R8 sat clear kept", {31'h0, flags_o[4]}, 32'h0);
    run("R8 sat set kept", 32'h12345678, 32'd3, 5'd0, 1'b0, 2'b01, 5'h10);
    chk("R8 sat bit", {31'h0, flags_o[4]}, 32'h1);
  endtask

  task automatic t_amt_src;
    run("R9 reg upper bits ignored", 32'hF0F0F0F0, 32'hFFFFFFE3, 5'd9, 1'b0, 2'b01, 5'h00);
    chk("R9 reg count 3", result_o, 32'h1E1E1E1E);
    run("R9 imm chosen", 32'hF0F0F0F0, 32'h00000003, 5'd8, 1'b1, 2'b01, 5'h00);
    chk("R9 imm count 8", result_o, 32'h00F0F0F0);
  endtask

  task automatic t_sweep;
    for (int m = 0; m < 4; m++)
      for (int n = 0; n < 32; n++) begin
        run("R1 R2 R3 R4 R7 sweep", 32'hA5C3_0F96 ^ (32'h1 << n), 32'(n) | 32'hA000_0000,
            5'(31 - n), 1'b0, 2'(m), 5'(n));
        run("R9 imm sweep", 32'h8000_0001 + 32'(n * 7919), 32'hFFFF_FFFF, 5'(n), 1'b1, 2'(m), 5'h00);
      end
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    t_reset_state();
    t_left();
    t_right();
    t_arith();
    t_zero_count();
    t_ov_sat();
    t_amt_src();
    t_sweep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule